// File: doc/BRIEF.md
# Multiplexed-Bus FIFO Host Interface

This block is the processor-facing register port of a serial link controller. A host on a multiplexed address/data bus sends an address phase qualified by an address-latch strobe. It then issues read or write strobes to one of four byte registers: control, threshold, transmit status and data. Writes to the data register feed a transmit FIFO. Reads from it drain a receive FIFO. The framing engine on the far side is represented by a drain port on the transmit FIFO and a fill port on the receive FIFO.

The status register reports how many more bytes the transmit FIFO can take. It also carries a threshold flag with hysteresis, which tells the host when a large block can be written. A bulk-transfer mode sends every access straight to the FIFOs when the address phase carries a qualifier bit. The host can then stream bytes without decoding a register address.

Top module: `mux_fifo_host_if`

## Requirements
- R1: After reset the control and threshold registers read 0x00, the status register reads 0xC0 (flag set, 64 free), `ad_oe_o` is 0 and `tx_valid_o` is 0.
- R2: The control register (select 0) and the threshold register (select 1) read back the last value written. The register select is `ad_i[1:0]` latched on the falling edge of `ale_i`.
- R3: A write to the data register (select 3) pushes the byte into the 64-deep transmit FIFO. Bytes leave on `tx_data_o` in write order, and one is consumed per `tx_pop_i` cycle while `tx_valid_o` is 1. A write when the FIFO is full is dropped.
- R4: A read of the data register pops the oldest byte from the receive FIFO. A read when that FIFO is empty returns 0x00 and changes nothing.
- R5: Status register bits 6:0 give the free transmit FIFO locations in binary (64 minus the byte count).
- R6: Status bit 7 is set whenever the free count is greater than or equal to threshold register bits 6:0.
- R7: Status bit 7 clears only after a transmit push leaves the free count below the threshold. Raising the threshold alone does not clear it.
- R8: When control bit 3 is 1 and `ad_i[6]` was 1 at the latching edge, every write pushes to the transmit FIFO and every read pops the receive FIFO, whatever the select bits are.
- R9: When `ad_i[6]` was 0, or control bit 3 is 0, the latched select bits address a register normally. With control bit 3 at 0, a latched `ad_i[6]` of 1 has no effect.
- R10: `rd_i` and `wr_i` are synchronised and act once per assertion, however long they are held.
- R11: Writes to the status register (select 2) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ale_i | input | 1 | Address latch strobe; address taken on its falling edge |
| ad_i | input | 8 | Bus address/data in |
| rd_i | input | 1 | Read strobe, active high, asynchronous |
| wr_i | input | 1 | Write strobe, active high, asynchronous |
| ad_o | output | 8 | Read data to the bus |
| ad_oe_o | output | 1 | Bus drive enable during a read |
| tx_data_o | output | 8 | Head byte of the transmit FIFO |
| tx_valid_o | output | 1 | Transmit FIFO not empty |
| tx_pop_i | input | 1 | Framing side consumes the head byte |
| rx_data_i | input | 8 | Received byte from the framing side |
| rx_push_i | input | 1 | Store `rx_data_i` into the receive FIFO |
| rx_full_o | output | 1 | Receive FIFO full |

## Verification
The hardest case to reach is the flag's hysteresis. The free count has to sit exactly at the threshold, then cross below it through a push. After that it must come back through a framing-side pop, and the threshold must be raised past the free count with no push in between. The stimulus fills the transmit FIFO to the boundary byte by byte and pops one byte from the drain port. It then rewrites the threshold and reads the status register after each step. Filling all 64 locations plus one more exercises the dropped write, and a 30-cycle write strobe in bulk mode checks that one strobe gives a single push.

// File: rtl/mfh_pkg.sv
`timescale 1ns/1ps
package mfh_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_TIL  = 2'd1,
    SEL_STAT = 2'd2,
    SEL_DATA = 2'd3
  } reg_sel_e;

  localparam int unsigned BULK_BIT = 3;
  localparam int unsigned QUAL_BIT = 6;
  localparam int unsigned TIL_W    = 7;
endpackage

// File: rtl/strobe_sync.sv
`timescale 1ns/1ps
module strobe_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  output logic level_o,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], strobe_i};
  end

  assign level_o = sh_q[STAGES-1];
  assign rise_o  = sh_q[STAGES-1] & ~sh_q[STAGES];

  // R10: one action per strobe
  a_r10_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/byte_fifo.sv
`timescale 1ns/1ps
module byte_fifo #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] rdata_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          push_ok, pop_ok;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign push_ok = push_i & ~full_o;
  assign pop_ok  = pop_i & ~empty_o;

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wp_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (pop_ok)  rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      cnt_q <= cnt_q + CW'(push_ok) - CW'(pop_ok);
    end
  end

  assign rdata_o = mem_q[rp_q];
  assign count_o = cnt_q;

  a_r3_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  a_r3_full_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i) |=> $stable(cnt_q));
  a_r4_empty_pop_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && pop_i && !push_i) |=> $stable(cnt_q));
endmodule

// File: rtl/mux_fifo_host_if.sv
`timescale 1ns/1ps
module mux_fifo_host_if
  import mfh_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ale_i,
  input  logic [7:0] ad_i,
  input  logic       rd_i,
  input  logic       wr_i,
  output logic [7:0] ad_o,
  output logic       ad_oe_o,
  output logic [7:0] tx_data_o,
  output logic       tx_valid_o,
  input  logic       tx_pop_i,
  input  logic [7:0] rx_data_i,
  input  logic       rx_push_i,
  output logic       rx_full_o
);
  reg_sel_e      lat_sel_q;
  logic          lat_qual_q;
  logic [7:0]    ctrl_q, til_q, rd_q;
  logic          flag_q, push_d_q;
  logic          rd_lvl, rd_rise, wr_lvl, wr_rise;
  logic          bulk, tx_push, rx_pop;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic [7:0]    tx_free, rx_head, rx_byte;
  logic          tx_full, tx_empty, rx_empty;
  logic [7:0]    status;

  // address phase captured on ALE falling edge
  always_ff @(negedge ale_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_sel_q  <= SEL_CTRL;
      lat_qual_q <= 1'b0;
    end else begin
      lat_sel_q  <= reg_sel_e'(ad_i[1:0]);
      lat_qual_q <= ad_i[QUAL_BIT];
    end
  end

  strobe_sync #(.STAGES(2)) u_rd_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .strobe_i(rd_i), .level_o(rd_lvl), .rise_o(rd_rise));
  strobe_sync #(.STAGES(2)) u_wr_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .strobe_i(wr_i), .level_o(wr_lvl), .rise_o(wr_rise));

  assign bulk    = ctrl_q[BULK_BIT] & lat_qual_q;
  assign tx_push = wr_rise & (bulk | (lat_sel_q == SEL_DATA));
  assign rx_pop  = rd_rise & (bulk | (lat_sel_q == SEL_DATA));

  byte_fifo #(.DEPTH(DEPTH), .DW(8)) u_tx_fifo (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(tx_push), .wdata_i(ad_i),
    .pop_i(tx_pop_i), .rdata_o(tx_data_o), .count_o(tx_cnt),
    .full_o(tx_full), .empty_o(tx_empty));

  byte_fifo #(.DEPTH(DEPTH), .DW(8)) u_rx_fifo (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(rx_push_i), .wdata_i(rx_data_i),
    .pop_i(rx_pop), .rdata_o(rx_head), .count_o(rx_cnt),
    .full_o(rx_full_o), .empty_o(rx_empty));

  assign tx_valid_o = ~tx_empty;
  assign tx_free    = 8'(DEPTH) - 8'(tx_cnt);
  assign rx_byte    = rx_empty ? 8'h00 : rx_head;
  assign status     = {flag_q, tx_free[TIL_W-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      til_q  <= '0;
    end else if (wr_rise && !bulk) begin
      unique case (lat_sel_q)
        SEL_CTRL: ctrl_q <= ad_i;
        SEL_TIL:  til_q  <= ad_i;
        default:  ;
      endcase
    end
  end

  // threshold flag: sets on level, clears only after a push crosses below
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q   <= 1'b1;
      push_d_q <= 1'b0;
    end else begin
      push_d_q <= tx_push & ~tx_full;
      if (tx_free >= {1'b0, til_q[TIL_W-1:0]}) flag_q <= 1'b1;
      else if (push_d_q)                       flag_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= '0;
    else if (rd_rise) begin
      if (bulk) rd_q <= rx_byte;
      else begin
        unique case (lat_sel_q)
          SEL_CTRL: rd_q <= ctrl_q;
          SEL_TIL:  rd_q <= til_q;
          SEL_STAT: rd_q <= status;
          SEL_DATA: rd_q <= rx_byte;
        endcase
      end
    end
  end

  assign ad_o    = rd_q;
  assign ad_oe_o = rd_lvl;

  a_r6_flag_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_free >= {1'b0, til_q[TIL_W-1:0]}) |=> flag_q);
  a_r7_flag_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !push_d_q) |=> flag_q);
  a_r8_bulk_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_rise && bulk && !tx_full) |=> (tx_cnt != '0));
  a_r11_stat_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_rise && !bulk && lat_sel_q == SEL_STAT) |=> ($stable(ctrl_q) && $stable(til_q)));
endmodule

// File: tb/mux_fifo_host_if_tb.sv
`timescale 1ns/1ps
module mux_fifo_host_if_tb;
  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       ale_i = 1'b0, rd_i = 1'b0, wr_i = 1'b0;
  logic [7:0] ad_i = '0, rx_data_i = '0;
  logic       tx_pop_i = 1'b0, rx_push_i = 1'b0;
  logic [7:0] ad_o, tx_data_o;
  logic       ad_oe_o, tx_valid_o, rx_full_o;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  mux_fifo_host_if u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .ale_i(ale_i), .ad_i(ad_i), .rd_i(rd_i), .wr_i(wr_i),
    .ad_o(ad_o), .ad_oe_o(ad_oe_o), .tx_data_o(tx_data_o), .tx_valid_o(tx_valid_o),
    .tx_pop_i(tx_pop_i), .rx_data_i(rx_data_i), .rx_push_i(rx_push_i), .rx_full_o(rx_full_o));

  // {read, qual, sel[1:0], data/expected[7:0]}
  localparam logic [11:0] VEC [14] = '{
    12'h800, 12'hAC0, 12'h0A5, 12'h8A5, 12'h13C, 12'h93C, 12'h311,
    12'h322, 12'hABE, 12'h2FF, 12'hABE, 12'hB00, 12'h407, 12'h807};

  function automatic string vec_req(int i);
    case (i)
      0:        return "R1";
      1:        return "R1/R5";
      3, 5:     return "R2";
      8:        return "R5";
      10:       return "R11";
      11:       return "R4";
      13:       return "R9";
      default:  return "R2";
    endcase
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic addr_phase(logic qual, logic [1:0] sel);
    @(negedge clk_i);
    ad_i  = {1'b0, qual, 4'b0, sel};
    ale_i = 1'b1;
    @(negedge clk_i);
    ale_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic bus_wr(logic qual, logic [1:0] sel, logic [7:0] d, int hold = 6);
    addr_phase(qual, sel);
    ad_i = d;
    wr_i = 1'b1;
    repeat (hold) @(negedge clk_i);
    wr_i = 1'b0;
    repeat (4) @(negedge clk_i);
  endtask

  task automatic bus_rd(logic qual, logic [1:0] sel, output logic [7:0] d);
    addr_phase(qual, sel);
    rd_i = 1'b1;
    repeat (6) @(negedge clk_i);
    d = ad_o;
    rd_i = 1'b0;
    repeat (4) @(negedge clk_i);
  endtask

  task automatic tx_pop();
    @(negedge clk_i);
    tx_pop_i = 1'b1;
    @(negedge clk_i);
    tx_pop_i = 1'b0;
  endtask

  task automatic rx_push(logic [7:0] d);
    @(negedge clk_i);
    rx_data_i = d;
    rx_push_i = 1'b1;
    @(negedge clk_i);
    rx_push_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    // R1: reset state at the ports
    check("R1 oe", {7'b0, ad_oe_o}, 8'h00);
    check("R1 tx_valid", {7'b0, tx_valid_o}, 8'h00);

    for (int i = 0; i < 14; i++) begin
      if (VEC[i][11]) begin
        bus_rd(VEC[i][10], VEC[i][9:8], d);
        check(vec_req(i), d, VEC[i][7:0]);
      end else begin
        bus_wr(VEC[i][10], VEC[i][9:8], VEC[i][7:0]);
      end
    end

    // R3: write order on drain port
    check("R3 head0", tx_data_o, 8'h11);
    tx_pop();
    check("R3 head1", tx_data_o, 8'h22);
    tx_pop();
    check("R3 empty", {7'b0, tx_valid_o}, 8'h00);

    // R6/R7 hysteresis, threshold 60
    for (int i = 0; i < 4; i++) bus_wr(1'b0, 2'd3, 8'(i));
    bus_rd(1'b0, 2'd2, d); check("R6 at level", d, 8'hBC);
    bus_wr(1'b0, 2'd3, 8'h44);
    bus_rd(1'b0, 2'd2, d); check("R7 cleared by push", d, 8'h3B);
    tx_pop();
    bus_rd(1'b0, 2'd2, d); check("R6 set by drain", d, 8'hBC);
    bus_wr(1'b0, 2'd1, 8'h3E);
    bus_rd(1'b0, 2'd2, d); check("R7 hold on threshold raise", d, 8'hBC);
    bus_wr(1'b0, 2'd3, 8'h55);
    bus_rd(1'b0, 2'd2, d); check("R7 cleared after push", d, 8'h3B);
    repeat (5) tx_pop();
    check("R3 drained", {7'b0, tx_valid_o}, 8'h00);

    // R3: fill, overflow drop
    for (int i = 0; i < 64; i++) bus_wr(1'b0, 2'd3, 8'(i));
    bus_wr(1'b0, 2'd3, 8'hEE);
    bus_rd(1'b0, 2'd2, d); check("R3/R5 full", d, 8'h00);
    repeat (63) tx_pop();
    check("R3 last byte", tx_data_o, 8'h3F);
    tx_pop();
    check("R3 overflow dropped", {7'b0, tx_valid_o}, 8'h00);

    // R8: bulk mode
    bus_wr(1'b0, 2'd0, 8'h08);
    bus_wr(1'b1, 2'd0, 8'h5A);
    check("R8 bulk write", tx_data_o, 8'h5A);
    bus_rd(1'b0, 2'd0, d); check("R8 ctrl untouched", d, 8'h08);
    rx_push(8'h77);
    rx_push(8'h88);
    bus_rd(1'b1, 2'd1, d); check("R8 bulk read", d, 8'h77);
    bus_rd(1'b0, 2'd3, d); check("R4 data read", d, 8'h88);
    bus_rd(1'b0, 2'd3, d); check("R4 empty read", d, 8'h00);
    tx_pop();

    // R10: long strobe acts once
    bus_wr(1'b1, 2'd2, 8'h99, 30);
    bus_rd(1'b0, 2'd2, d); check("R10 single push", d, 8'hBF);
    check("R10 data", tx_data_o, 8'h99);

    finish_run();
  end
endmodule